// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address by walking a two-level page table held in memory. A walk starts with a one-cycle start pulse that carries the virtual address, the access kind (read or write), the table base register, a paging-enable flag, a large-page-enable flag and an address mask. The walker fetches the first-level (directory) entry. Unless that entry maps a 4 MB page, it then fetches the second-level (table) entry. Every entry address is ANDed with the mask input before it leaves the block.

On its way through the tables the walker sets the accessed and dirty flags in memory where required. It finishes with either a done pulse or a fault pulse. With done it presents a physical address of up to 40 bits, a large-page flag and the combined user and write permission bits. With a fault it presents a flag that tells a reserved-bit fault from a not-present fault. Deciding whether the access is finally allowed is left to the consumer.

The memory port carries one request at a time, under a valid/ready handshake. A read returns its data later with a response-valid strobe. A write is complete once the port accepts it.

Top module: `ptw_walker`

## Requirements
- R1: With paging disabled at start, the walk makes no memory access and ends in done with physAddr equal to the zero-extended virtual address, pageLarge=0, permUser=1 and permWrite=1.
- R2: The directory entry is read from ({base[31:12], va[31:22], 2'b00} & mask). The table entry is read from ({dirEntry[31:12], va[21:12], 2'b00} & mask). Request addresses are always word aligned.
- R3: An entry with bit 0 (present) clear ends the walk in fault with faultRsvd=0, and that entry is not written back.
- R4: A directory entry with bit 7 set, while large pages are enabled, ends the walk after one read with pageLarge=1 and physAddr = {entry[20:13], entry[31:22], va[21:0]}. With large pages disabled, bit 7 is ignored and the table entry is fetched.
- R5: A large-page directory entry with bit 21 set ends the walk in fault with faultRsvd=1, and nothing is written.
- R6: For a small page, a directory entry whose bit 5 (accessed) is clear is written back with bit 5 set before the table entry is read. A directory entry whose accessed bit is already set is not written.
- R7: The final entry is written back when its accessed bit is clear, or when the access is a write and bit 6 (dirty) is clear. The value written has bit 5 set, and also bit 6 set for a write. An entry that needs neither is not written.
- R8: permUser is the AND of bit 2 across the entries used, and permWrite is bounded by the AND of bit 1 across them. For a small page, physAddr = {8'b0, tableEntry[31:12], va[11:0]}.
- R9: When the final entry's dirty bit is still clear at the end of the walk, permWrite is 0.
- R10: walkDone and walkFault are one-cycle pulses, and busy is low in the cycle after either. A start pulse while busy is ignored and does not change the result.
- R11: A request held without ready keeps its valid, address, direction and data unchanged. Walks still complete correctly when ready is withheld on alternate cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| walkStart | input | 1 | One-cycle pulse that starts a walk |
| virtAddr | input | 32 | Virtual address to translate |
| isWrite | input | 1 | Access is a write |
| pagingOn | input | 1 | Paging enabled; when low the address passes through |
| largeOn | input | 1 | Enables 4 MB directory mappings |
| dirBase | input | 32 | Table base register; low 12 bits are ignored |
| addrMask | input | 32 | Mask ANDed into every entry address |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | Request is a write |
| memReqAddr | output | 32 | Request byte address |
| memReqWdata | output | 32 | Write data |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| walkDone | output | 1 | Translation complete pulse |
| walkFault | output | 1 | Walk ended in a fault pulse |
| faultRsvd | output | 1 | Fault was reserved-bit (1) or not-present (0) |
| physAddr | output | 40 | Translated physical address |
| pageLarge | output | 1 | Result is a 4 MB page |
| permUser | output | 1 | Combined user permission |
| permWrite | output | 1 | Combined write permission |

## Verification
The hardest situation to reach is a start pulse that arrives mid-walk while a write-back is stalled on the memory port. Only then are the ignore-while-busy rule and the request-hold rule exercised together. The bench reaches it with a memory model that withholds ready on every other cycle and issues a second start with a different address in the cycle after the first. It then checks that only one done pulse appears, that the result belongs to the first address, and that no extra reads follow. Entry values are also chosen so that a walk lands on each of the write-back decisions in turn: accessed only, accessed plus dirty, and none.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ENTRY_W = 32;
  localparam int BIT_P   = 0;
  localparam int BIT_RW  = 1;
  localparam int BIT_US  = 2;
  localparam int BIT_A   = 5;
  localparam int BIT_D   = 6;
  localparam int BIT_PS  = 7;
  localparam int BIT_RSV = 21;
  localparam int EXT_LO  = 13;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PDE_RD,
    ST_PDE_WAIT,
    ST_PDE_WB,
    ST_PTE_RD,
    ST_PTE_WAIT,
    ST_PTE_WB,
    ST_DONE,
    ST_FAULT
  } walkState_e;

  typedef struct packed {
    logic capture;
    logic loadPde;
    logic loadPte;
    logic commitPde;
    logic commitPte;
    logic markRsvd;
    logic selPte;
  } walkCtl_t;

  typedef struct packed {
    logic pdePresent;
    logic pdeLarge;
    logic pdeRsvd;
    logic pdeNeedWb;
    logic ptePresent;
    logic pteNeedWb;
  } walkSts_t;

endpackage

// File: rtl/ptw_dpath.sv
module ptw_dpath
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [31:0]       virtAddr,
  input  logic              isWrite,
  input  logic              pagingOn,
  input  logic              largeOn,
  input  logic [31:0]       dirBase,
  input  logic [31:0]       addrMask,
  input  logic [31:0]       memRspData,
  output walkSts_t          sts,
  output logic [31:0]       memReqAddr,
  output logic [31:0]       memReqWdata,
  output logic              faultRsvd,
  output logic [PA_W-1:0]   physAddr,
  output logic              pageLarge,
  output logic              permUser,
  output logic              permWrite
);

  localparam int EXT_W = PA_W - 32;

  logic [31:0]        vaReg;
  logic [31:0]        baseReg;
  logic [31:0]        maskReg;
  logic               writeReg;
  logic               largeEnReg;
  logic               bypassReg;
  logic               rsvdReg;
  logic [ENTRY_W-1:0] pdeReg;
  logic [ENTRY_W-1:0] pteReg;

  logic [31:0]        pdeAddr;
  logic [31:0]        pteAddr;
  logic [ENTRY_W-1:0] pdeWbVal;
  logic [ENTRY_W-1:0] pteWbVal;
  logic               isLarge;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg      <= '0;
      baseReg    <= '0;
      maskReg    <= '0;
      writeReg   <= 1'b0;
      largeEnReg <= 1'b0;
      bypassReg  <= 1'b0;
      rsvdReg    <= 1'b0;
      pdeReg     <= '0;
      pteReg     <= '0;
    end else begin
      if (ctl.capture) begin
        vaReg      <= virtAddr;
        baseReg    <= dirBase;
        maskReg    <= addrMask;
        writeReg   <= isWrite;
        largeEnReg <= largeOn;
        bypassReg  <= ~pagingOn;
        rsvdReg    <= 1'b0;
      end
      if (ctl.markRsvd) rsvdReg <= 1'b1;
      if (ctl.loadPde)        pdeReg <= memRspData;
      else if (ctl.commitPde) pdeReg <= pdeWbVal;
      if (ctl.loadPte)        pteReg <= memRspData;
      else if (ctl.commitPte) pteReg <= pteWbVal;
    end
  end

  assign isLarge = pdeReg[BIT_PS] & largeEnReg;

  always_comb begin
    pdeWbVal = pdeReg;
    pdeWbVal[BIT_A] = 1'b1;
    if (isLarge && writeReg) pdeWbVal[BIT_D] = 1'b1;
    pteWbVal = pteReg;
    pteWbVal[BIT_A] = 1'b1;
    if (writeReg) pteWbVal[BIT_D] = 1'b1;
  end

  assign pdeAddr = {baseReg[31:12], vaReg[31:22], 2'b00} & maskReg;
  assign pteAddr = {pdeReg[31:12], vaReg[21:12], 2'b00} & maskReg;

  assign memReqAddr  = ctl.selPte ? pteAddr : pdeAddr;
  assign memReqWdata = ctl.selPte ? pteWbVal : pdeWbVal;

  always_comb begin
    sts.pdePresent = pdeReg[BIT_P];
    sts.pdeLarge   = isLarge;
    sts.pdeRsvd    = isLarge & pdeReg[BIT_RSV];
    sts.pdeNeedWb  = ~pdeReg[BIT_A] | (isLarge & writeReg & ~pdeReg[BIT_D]);
    sts.ptePresent = pteReg[BIT_P];
    sts.pteNeedWb  = ~pteReg[BIT_A] | (writeReg & ~pteReg[BIT_D]);
  end

  always_comb begin
    if (bypassReg) begin
      physAddr  = {{EXT_W{1'b0}}, vaReg};
      pageLarge = 1'b0;
      permUser  = 1'b1;
      permWrite = 1'b1;
    end else if (isLarge) begin
      physAddr  = {pdeReg[EXT_LO +: EXT_W], pdeReg[31:22], vaReg[21:0]};
      pageLarge = 1'b1;
      permUser  = pdeReg[BIT_US];
      permWrite = pdeReg[BIT_RW] & pdeReg[BIT_D];
    end else begin
      physAddr  = {{EXT_W{1'b0}}, pteReg[31:12], vaReg[11:0]};
      pageLarge = 1'b0;
      permUser  = pdeReg[BIT_US] & pteReg[BIT_US];
      permWrite = pdeReg[BIT_RW] & pteReg[BIT_RW] & pteReg[BIT_D];
    end
  end

  assign faultRsvd = rsvdReg;

  // R2
  addr_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqAddr[1:0] == 2'b00);

  // R6
  pte_after_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadPte |-> pdeReg[BIT_A]);

  // R7
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commitPte && writeReg |=> pteReg[BIT_D] && pteReg[BIT_A]);

endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     walkStart,
  input  logic     pagingOn,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  walkSts_t sts,
  output walkCtl_t ctl,
  output logic     memReqValid,
  output logic     memReqWrite,
  output logic     walkDone,
  output logic     walkFault,
  output logic     busy
);

  walkState_e state;
  walkState_e nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt         = state;
    ctl         = '0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (walkStart) begin
          ctl.capture = 1'b1;
          nxt = pagingOn ? ST_PDE_RD : ST_DONE;
        end
      end
      ST_PDE_RD: begin
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_PDE_WAIT;
      end
      ST_PDE_WAIT: begin
        if (memRspValid) begin
          ctl.loadPde = 1'b1;
          nxt = ST_PDE_WB;
        end
      end
      ST_PDE_WB: begin
        if (!sts.pdePresent) begin
          nxt = ST_FAULT;
        end else if (sts.pdeRsvd) begin
          ctl.markRsvd = 1'b1;
          nxt = ST_FAULT;
        end else if (sts.pdeNeedWb) begin
          memReqValid = 1'b1;
          memReqWrite = 1'b1;
          if (memReqReady) begin
            ctl.commitPde = 1'b1;
            nxt = sts.pdeLarge ? ST_DONE : ST_PTE_RD;
          end
        end else begin
          nxt = sts.pdeLarge ? ST_DONE : ST_PTE_RD;
        end
      end
      ST_PTE_RD: begin
        ctl.selPte  = 1'b1;
        memReqValid = 1'b1;
        if (memReqReady) nxt = ST_PTE_WAIT;
      end
      ST_PTE_WAIT: begin
        ctl.selPte = 1'b1;
        if (memRspValid) begin
          ctl.loadPte = 1'b1;
          nxt = ST_PTE_WB;
        end
      end
      ST_PTE_WB: begin
        ctl.selPte = 1'b1;
        if (!sts.ptePresent) begin
          nxt = ST_FAULT;
        end else if (sts.pteNeedWb) begin
          memReqValid = 1'b1;
          memReqWrite = 1'b1;
          if (memReqReady) begin
            ctl.commitPte = 1'b1;
            nxt = ST_DONE;
          end
        end else begin
          nxt = ST_DONE;
        end
      end
      ST_DONE:  nxt = ST_IDLE;
      ST_FAULT: nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  assign walkDone  = (state == ST_DONE);
  assign walkFault = (state == ST_FAULT);
  assign busy      = (state != ST_IDLE);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid && $stable(memReqWrite));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (walkDone || walkFault) |=> !walkDone && !walkFault && !busy);

  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy && walkStart && !walkDone && !walkFault |=> busy);

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            walkStart,
  input  logic [31:0]     virtAddr,
  input  logic            isWrite,
  input  logic            pagingOn,
  input  logic            largeOn,
  input  logic [31:0]     dirBase,
  input  logic [31:0]     addrMask,
  output logic            memReqValid,
  input  logic            memReqReady,
  output logic            memReqWrite,
  output logic [31:0]     memReqAddr,
  output logic [31:0]     memReqWdata,
  input  logic            memRspValid,
  input  logic [31:0]     memRspData,
  output logic            busy,
  output logic            walkDone,
  output logic            walkFault,
  output logic            faultRsvd,
  output logic [PA_W-1:0] physAddr,
  output logic            pageLarge,
  output logic            permUser,
  output logic            permWrite
);

  walkCtl_t ctl;
  walkSts_t sts;

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .walkStart   (walkStart),
    .pagingOn    (pagingOn),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .sts         (sts),
    .ctl         (ctl),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .walkDone    (walkDone),
    .walkFault   (walkFault),
    .busy        (busy)
  );

  ptw_dpath #(.PA_W(PA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .virtAddr    (virtAddr),
    .isWrite     (isWrite),
    .pagingOn    (pagingOn),
    .largeOn     (largeOn),
    .dirBase     (dirBase),
    .addrMask    (addrMask),
    .memRspData  (memRspData),
    .sts         (sts),
    .memReqAddr  (memReqAddr),
    .memReqWdata (memReqWdata),
    .faultRsvd   (faultRsvd),
    .physAddr    (physAddr),
    .pageLarge   (pageLarge),
    .permUser    (permUser),
    .permWrite   (permWrite)
  );

  // R11
  req_addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr) && $stable(memReqWdata));

endmodule

// File: tb/sim_ptw_walker.sv
module sim_ptw_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        walkStart = 1'b0;
  logic [31:0] virtAddr = '0;
  logic        isWrite = 1'b0;
  logic        pagingOn = 1'b0;
  logic        largeOn = 1'b0;
  logic [31:0] dirBase = 32'h0000_1000;
  logic [31:0] addrMask = 32'hFFFF_FFFF;
  logic        memReqValid, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memReqReady;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        busy, walkDone, walkFault, faultRsvd;
  logic [39:0] physAddr;
  logic        pageLarge, permUser, permWrite;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ptw_walker u0 (
    .clk(clk), .rstN(rstN), .walkStart(walkStart), .virtAddr(virtAddr),
    .isWrite(isWrite), .pagingOn(pagingOn), .largeOn(largeOn),
    .dirBase(dirBase), .addrMask(addrMask),
    .memReqValid(memReqValid), .memReqReady(memReqReady),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr),
    .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .busy(busy), .walkDone(walkDone),
    .walkFault(walkFault), .faultRsvd(faultRsvd), .physAddr(physAddr),
    .pageLarge(pageLarge), .permUser(permUser), .permWrite(permWrite)
  );

  // memory model: 16 KB, word indexed
  logic [31:0] mem [0:4095];
  logic        stallMode = 1'b0;
  logic        readyR = 1'b1;
  logic        rspV = 1'b0;
  logic [31:0] rspD = '0;
  int          rdCnt = 0;
  int          wrCnt = 0;
  logic [31:0] rdLog [0:63];
  logic [31:0] wrAddrLog [0:63];
  logic [31:0] wrDataLog [0:63];

  assign memReqReady = readyR;
  assign memRspValid = rspV;
  assign memRspData  = rspD;

  always @(posedge clk) begin
    readyR <= stallMode ? ~readyR : 1'b1;
    rspV   <= 1'b0;
    if (memReqValid && memReqReady) begin
      if (memReqWrite) begin
        mem[memReqAddr[13:2]] <= memReqWdata;
        wrAddrLog[wrCnt % 64] <= memReqAddr;
        wrDataLog[wrCnt % 64] <= memReqWdata;
        wrCnt <= wrCnt + 1;
      end else begin
        rdLog[rdCnt % 64] <= memReqAddr;
        rdCnt <= rdCnt + 1;
        rspV  <= 1'b1;
        rspD  <= mem[memReqAddr[13:2]];
      end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // results of the last walk
  logic        gDone, gFault, gRsvd, gLarge, gUser, gWrite, gPulseOk;
  logic [39:0] gPhys;
  int          gDoneCnt, rdBase, wrBase;

  task automatic runWalk(input logic [31:0] va, input logic wr, input logic pg,
                         input logic lg, input logic [31:0] va2, input logic second);
    rdBase = rdCnt;
    wrBase = wrCnt;
    gDone = 0; gFault = 0; gDoneCnt = 0; gPulseOk = 1;
    @(negedge clk);
    virtAddr = va; isWrite = wr; pagingOn = pg; largeOn = lg; walkStart = 1'b1;
    @(negedge clk);
    walkStart = 1'b0;
    if (second) begin
      virtAddr = va2;
      walkStart = 1'b1;
    end
    for (int i = 0; i < 200; i++) begin
      if (i == 1) walkStart = 1'b0;
      if (walkDone || walkFault) begin
        gDone = walkDone; gFault = walkFault; gRsvd = faultRsvd;
        gPhys = physAddr; gLarge = pageLarge; gUser = permUser; gWrite = permWrite;
        gDoneCnt++;
        walkStart = 1'b0;
        @(negedge clk);
        if (walkDone || walkFault || busy) gPulseOk = 0;
        break;
      end
      @(negedge clk);
    end
    walkStart = 1'b0;
    if (!(gDone || gFault)) begin
      total++; bad++;
      $display("FAIL walk timeout act=0 exp=1");
    end
  endtask

  task automatic tReset;
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", walkDone, 0);
    chk("R10 reset fault", walkFault, 0);
    chk("R11 reset req", memReqValid, 0);
  endtask

  task automatic tBypass;
    runWalk(32'hDEAD_BEEF, 1'b1, 1'b0, 1'b0, 0, 0);
    chk("R1 done", gDone, 1);
    chk("R1 phys", gPhys, 40'h00DEADBEEF);
    chk("R1 perms", {gLarge, gUser, gWrite}, 3'b011);
    chk("R1 no access", (rdCnt - rdBase) + (wrCnt - wrBase), 0);
    chk("R10 pulse", gPulseOk, 1);
  endtask

  task automatic tSmallRead;
    mem[32'h1004 >> 2] = 32'h0000_2007;
    mem[32'h2014 >> 2] = 32'hABCD_E007;
    runWalk(32'h0040_5123, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R8 phys small", gPhys, 40'h00ABCDE123);
    chk("R2 pde addr", rdLog[rdBase % 64], 32'h1004);
    chk("R2 pte addr", rdLog[(rdBase + 1) % 64], 32'h2014);
    chk("R6 wb count", wrCnt - wrBase, 2);
    chk("R6 pde wb", {wrAddrLog[wrBase % 64], wrDataLog[wrBase % 64]}, {32'h1004, 32'h0000_2027});
    chk("R7 pte wb read", {wrAddrLog[(wrBase + 1) % 64], wrDataLog[(wrBase + 1) % 64]},
        {32'h2014, 32'hABCD_E027});
    chk("R9 no write perm", {gUser, gWrite}, 2'b10);
  endtask

  task automatic tSmallWrite;
    runWalk(32'h0040_5123, 1'b1, 1'b1, 1'b0, 0, 0);
    chk("R6 pde no wb", wrCnt - wrBase, 1);
    chk("R7 pte wb write", {wrAddrLog[wrBase % 64], wrDataLog[wrBase % 64]},
        {32'h2014, 32'hABCD_E067});
    chk("R8 write perm", {gUser, gWrite}, 2'b11);
  endtask

  task automatic tPermAnd;
    mem[32'h1008 >> 2] = 32'h0000_3023;
    mem[32'h3018 >> 2] = 32'h1111_1065;
    runWalk(32'h0080_6ABC, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R8 and perms", {gUser, gWrite}, 2'b00);
    chk("R7 no wb", wrCnt - wrBase, 0);
    chk("R8 phys", gPhys, 40'h0011111ABC);
  endtask

  task automatic tLarge;
    mem[32'h10C0 >> 2] = 32'h0C8B_4087;
    runWalk(32'h0C12_3456, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R4 large done", gDone, 1);
    chk("R4 large phys", gPhys, 40'h5A0C923456);
    chk("R4 one read", rdCnt - rdBase, 1);
    chk("R7 large wb", wrDataLog[wrBase % 64], 32'h0C8B_40E7);
    chk("R4 flags", {gLarge, gUser, gWrite}, 3'b111);
  endtask

  task automatic tLargeOff;
    mem[32'h100C >> 2] = 32'h0000_3087;
    mem[32'h3004 >> 2] = 32'h7777_7067;
    runWalk(32'h00C0_1000, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R4 ps ignored", {gDone, gLarge}, 2'b10);
    chk("R4 two reads", rdCnt - rdBase, 2);
    chk("R4 phys small", gPhys, 40'h0077777000);
    chk("R6 pde wb", wrDataLog[wrBase % 64], 32'h0000_30A7);
  endtask

  task automatic tRsvd;
    mem[32'h1010 >> 2] = 32'h0020_0087;
    runWalk(32'h0100_0000, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R5 fault", {gFault, gRsvd}, 2'b11);
    chk("R5 no write", wrCnt - wrBase, 0);
    chk("R10 fault pulse", gPulseOk, 1);
  endtask

  task automatic tPdeNp;
    mem[32'h1014 >> 2] = 32'h0000_2006;
    runWalk(32'h0140_0000, 1'b1, 1'b1, 1'b1, 0, 0);
    chk("R3 pde np", {gFault, gRsvd}, 2'b10);
    chk("R3 pde np io", {rdCnt - rdBase, wrCnt - wrBase}, {32'd1, 32'd0});
  endtask

  task automatic tPteNp;
    mem[32'h1018 >> 2] = 32'h0000_3027;
    mem[32'h3008 >> 2] = 32'h0000_0000;
    runWalk(32'h0180_2000, 1'b1, 1'b1, 1'b0, 0, 0);
    chk("R3 pte np", {gFault, gRsvd}, 2'b10);
    chk("R3 pte np io", {rdCnt - rdBase, wrCnt - wrBase}, {32'd2, 32'd0});
  endtask

  task automatic tMask;
    dirBase = 32'h0010_1000;
    addrMask = 32'hFFEF_FFFF;
    runWalk(32'h0040_5123, 1'b0, 1'b1, 1'b0, 0, 0);
    chk("R2 masked pde addr", rdLog[rdBase % 64], 32'h1004);
    chk("R2 masked phys", gPhys, 40'h00ABCDE123);
    dirBase = 32'h0000_1000;
    addrMask = 32'hFFFF_FFFF;
  endtask

  task automatic tBusyStall;
    mem[32'h2014 >> 2] = 32'hABCD_E007;
    stallMode = 1'b1;
    runWalk(32'h0040_5123, 1'b1, 1'b1, 1'b0, 32'h00C0_1000, 1);
    chk("R10 first result", gPhys, 40'h00ABCDE123);
    chk("R10 single pulse", {gDoneCnt[7:0], gPulseOk}, {8'd1, 1'b1});
    repeat (6) @(negedge clk);
    chk("R10 no restart", {busy, 32'(rdCnt - rdBase)}, {1'b0, 32'd2});
    chk("R11 stalled wb", mem[32'h2014 >> 2], 32'hABCD_E067);
    stallMode = 1'b0;
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tBypass();
    tSmallRead();
    tSmallWrite();
    tPermAnd();
    tLarge();
    tLargeOff();
    tRsvd();
    tPdeNp();
    tPteNp();
    tMask();
    tBusyStall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule